// File: doc/BRIEF.md
# Subcode Shift Clock Receiver

This block collects the six R to W subcode channel bits that a disc DSP sends once per subcode frame over a three-wire serial link: frame sync, block sync and serial data. When the direction select is low, the block produces the shift clock itself. Each frame-sync rising edge starts a burst of eight clock pulses, and the period and pulse widths are counted in master-clock cycles. When the direction select is high, a shift clock from outside is brought into the master-clock domain and used instead. In both modes the serial line is sampled on shift-clock rising edges. Each burst carries eight bits (P through W). The block keeps the last six of them as one symbol.

Completed symbols leave on a valid/ready stream together with a flag that marks whether a block-sync edge arrived since the previous symbol. The disc cannot be paused, so the stream does not stall the link. A pending symbol is held while ready is low, and a newer symbol replaces it. The consumer must therefore accept each symbol within one subcode frame. The speed select chooses one of two timing sets. The short set supports block periods down to about 6.65 ms (double speed), and the long set supports the 13.3 ms normal-speed period.

Top module: `subcode_shift_rx`

## Requirements
- R1: While rst_n is low and directly after it rises, sclk_o is low, sym_valid_o is low and no burst is running.
- R2: With dir_sel_i low, a frame_sync_i rising edge starts a burst. After a lead-in of DLY cycles, sclk_o makes exactly 8 pulses. Each pulse is high for HI cycles and low for LO cycles.
- R3: speed_sel_i is sampled when a burst starts. Low selects DLY_FAST/HI_FAST/LO_FAST (defaults 208/32/32). High selects DLY_SLOW/HI_SLOW/LO_SLOW (defaults 320/128/128).
- R4: With dir_sel_i high, sclk_o stays low. Bits are taken on rising edges of sclk_ext_i after a two-flop synchronizer, and sdata_i passes through a matching synchronizer.
- R5: Of the 8 bits in a frame, the first two (P, Q) are dropped. The third bit (R) is placed in sym_data_o[5], and the last bit (W) is placed in sym_data_o[0].
- R6: sym_valid_o rises one cycle after the eighth bit is sampled. It stays high, with sym_data_o and sym_blk_o unchanged, until a cycle with sym_ready_i high. A symbol completed while one is still pending replaces it.
- R7: sym_blk_o is 1 when a block_sync_i rising edge was seen after the previous symbol was emitted, and 0 otherwise.
- R8: In generator mode, a frame_sync_i rising edge during a running burst is ignored. The burst still produces 8 pulses and one symbol.
- R9: In external-clock mode, a frame_sync_i rising edge clears the bit count and discards a partly received frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync_i | input | 1 | Frame sync, one rising edge per subcode frame |
| block_sync_i | input | 1 | Block sync, one rising edge per subcode block |
| sdata_i | input | 1 | Serial subcode data |
| dir_sel_i | input | 1 | 0: block generates the shift clock; 1: shift clock comes from outside |
| speed_sel_i | input | 1 | 0: double-speed timing set; 1: normal-speed timing set |
| sclk_ext_i | input | 1 | External shift clock (used when dir_sel_i is 1) |
| sclk_o | output | 1 | Generated shift clock (low when dir_sel_i is 1) |
| sym_data_o | output | 6 | R to W symbol, R in bit 5 |
| sym_blk_o | output | 1 | Block-sync flag travelling with the symbol |
| sym_valid_o | output | 1 | Symbol valid |
| sym_ready_i | input | 1 | Consumer ready |

## Verification
The hardest cases to reach from the ports are a second frame-sync edge arriving in the middle of a generated burst, and a symbol overwritten while the consumer stalls. The bench drives serial data in reaction to the block's own sclk_o edges. This lets it inject a frame-sync pulse after a chosen number of pulses within the burst. For the overwrite case, the bench holds ready low across two complete bursts, checks that the first symbol is held unchanged, and then checks that only the second symbol is delivered.

// File: rtl/subcode_rx_pkg.sv
package subcode_rx_pkg;
  typedef enum logic [1:0] {
    GEN_IDLE  = 2'd0,
    GEN_LEAD  = 2'd1,
    GEN_HIGH  = 2'd2,
    GEN_LOW   = 2'd3
  } gen_state_t;

  localparam int unsigned BITS_PER_FRAME = 8;
  localparam int unsigned SYM_W          = 6;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/subcode_sync2.sv
module subcode_sync2 #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= async_i[g];
        s2 <= s1;
      end
    end
    assign sync_o[g] = s2;
  end
endmodule

// File: rtl/subcode_sclk_gen.sv
module subcode_sclk_gen
  import subcode_rx_pkg::*;
#(
  parameter int unsigned DLY_FAST = 208,
  parameter int unsigned HI_FAST  = 32,
  parameter int unsigned LO_FAST  = 32,
  parameter int unsigned DLY_SLOW = 320,
  parameter int unsigned HI_SLOW  = 128,
  parameter int unsigned LO_SLOW  = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic start_i,
  input  logic speed_i,
  output logic start_ack_o,
  output logic sclk_o,
  output logic rise_o
);
  localparam int unsigned MAXC = max3(max3(DLY_FAST, HI_FAST, LO_FAST),
                                      max3(DLY_SLOW, HI_SLOW, LO_SLOW), 2);
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam int unsigned NW   = $clog2(BITS_PER_FRAME + 1);
  localparam logic [NW-1:0] NLAST = NW'(BITS_PER_FRAME);

  gen_state_t    state;
  logic [CW-1:0] cnt;
  logic [NW-1:0] npulse;
  logic          spd_q;
  logic [CW-1:0] dly_m1, hi_m1, lo_m1, dly_new_m1;

  always_comb begin
    dly_new_m1 = speed_i ? CW'(DLY_SLOW - 1) : CW'(DLY_FAST - 1);
    dly_m1     = spd_q   ? CW'(DLY_SLOW - 1) : CW'(DLY_FAST - 1);
    hi_m1      = spd_q   ? CW'(HI_SLOW - 1)  : CW'(HI_FAST - 1);
    lo_m1      = spd_q   ? CW'(LO_SLOW - 1)  : CW'(LO_FAST - 1);
  end

  assign start_ack_o = en_i && start_i && (state == GEN_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= GEN_IDLE;
      cnt    <= '0;
      npulse <= '0;
      spd_q  <= 1'b0;
      sclk_o <= 1'b0;
      rise_o <= 1'b0;
    end else begin
      rise_o <= 1'b0;
      if (!en_i) begin
        state  <= GEN_IDLE;
        sclk_o <= 1'b0;
      end else begin
        unique case (state)
          GEN_IDLE: if (start_i) begin
            state  <= GEN_LEAD;
            spd_q  <= speed_i;
            cnt    <= dly_new_m1;
            npulse <= '0;
          end
          GEN_LEAD: if (cnt == '0) begin
            state  <= GEN_HIGH;
            cnt    <= hi_m1;
            sclk_o <= 1'b1;
            rise_o <= 1'b1;
            npulse <= npulse + 1'b1;
          end else cnt <= cnt - 1'b1;
          GEN_HIGH: if (cnt == '0) begin
            state  <= GEN_LOW;
            cnt    <= lo_m1;
            sclk_o <= 1'b0;
          end else cnt <= cnt - 1'b1;
          GEN_LOW: if (cnt == '0) begin
            if (npulse == NLAST) begin
              state <= GEN_IDLE;
            end else begin
              state  <= GEN_HIGH;
              cnt    <= hi_m1;
              sclk_o <= 1'b1;
              rise_o <= 1'b1;
              npulse <= npulse + 1'b1;
            end
          end else cnt <= cnt - 1'b1;
          default: state <= GEN_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/subcode_sym_asm.sv
module subcode_sym_asm
  import subcode_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_ev_i,
  input  logic             bit_i,
  input  logic             restart_i,
  input  logic             blk_ev_i,
  input  logic             ready_i,
  output logic [SYM_W-1:0] data_o,
  output logic             blk_o,
  output logic             valid_o
);
  localparam int unsigned BW = $clog2(BITS_PER_FRAME);
  localparam logic [BW-1:0] BLAST = BW'(BITS_PER_FRAME - 1);

  logic [SYM_W-1:0] shreg;
  logic [BW-1:0]    nbit;
  logic             blk_pend;
  logic             emit;

  assign emit = bit_ev_i && !restart_i && (nbit == BLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      nbit     <= '0;
      blk_pend <= 1'b0;
      data_o   <= '0;
      blk_o    <= 1'b0;
      valid_o  <= 1'b0;
    end else begin
      if (restart_i) begin
        nbit <= '0;
      end else if (bit_ev_i) begin
        shreg <= {shreg[SYM_W-2:0], bit_i};
        nbit  <= emit ? '0 : nbit + 1'b1;
      end
      blk_pend <= emit ? 1'b0 : (blk_pend | blk_ev_i);
      if (emit) begin
        data_o  <= {shreg[SYM_W-2:0], bit_i};
        blk_o   <= blk_pend | blk_ev_i;
        valid_o <= 1'b1;
      end else if (valid_o && ready_i) begin
        valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/subcode_shift_rx.sv
module subcode_shift_rx
  import subcode_rx_pkg::*;
#(
  parameter int unsigned DLY_FAST = 208,
  parameter int unsigned HI_FAST  = 32,
  parameter int unsigned LO_FAST  = 32,
  parameter int unsigned DLY_SLOW = 320,
  parameter int unsigned HI_SLOW  = 128,
  parameter int unsigned LO_SLOW  = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_sync_i,
  input  logic       block_sync_i,
  input  logic       sdata_i,
  input  logic       dir_sel_i,
  input  logic       speed_sel_i,
  input  logic       sclk_ext_i,
  output logic       sclk_o,
  output logic [5:0] sym_data_o,
  output logic       sym_blk_o,
  output logic       sym_valid_o,
  input  logic       sym_ready_i
);
  logic [3:0] raw_in, syn_in;
  logic       fs_d, bs_d, ek_d;
  logic       fs_rise, bs_rise, ek_rise;
  logic       gen_ack, gen_rise;
  logic       bit_ev, bit_val, restart;

  assign raw_in = {sclk_ext_i, block_sync_i, frame_sync_i, sdata_i};

  subcode_sync2 #(.W(4)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(raw_in), .sync_o(syn_in)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_d <= 1'b0;
      bs_d <= 1'b0;
      ek_d <= 1'b0;
    end else begin
      fs_d <= syn_in[1];
      bs_d <= syn_in[2];
      ek_d <= syn_in[3];
    end
  end

  assign fs_rise = syn_in[1] & ~fs_d;
  assign bs_rise = syn_in[2] & ~bs_d;
  assign ek_rise = syn_in[3] & ~ek_d;

  subcode_sclk_gen #(
    .DLY_FAST(DLY_FAST), .HI_FAST(HI_FAST), .LO_FAST(LO_FAST),
    .DLY_SLOW(DLY_SLOW), .HI_SLOW(HI_SLOW), .LO_SLOW(LO_SLOW)
  ) u_gen (
    .clk(clk), .rst_n(rst_n), .en_i(~dir_sel_i), .start_i(fs_rise),
    .speed_i(speed_sel_i), .start_ack_o(gen_ack), .sclk_o(sclk_o),
    .rise_o(gen_rise)
  );

  assign bit_ev  = dir_sel_i ? ek_rise   : gen_rise;
  assign bit_val = dir_sel_i ? syn_in[0] : sdata_i;
  assign restart = dir_sel_i ? fs_rise   : gen_ack;

  subcode_sym_asm u_asm (
    .clk(clk), .rst_n(rst_n), .bit_ev_i(bit_ev), .bit_i(bit_val),
    .restart_i(restart), .blk_ev_i(bs_rise), .ready_i(sym_ready_i),
    .data_o(sym_data_o), .blk_o(sym_blk_o), .valid_o(sym_valid_o)
  );
endmodule

// File: rtl/subcode_shift_rx_chk.sv
module subcode_shift_rx_chk #(
  parameter int unsigned DLY_FAST = 208,
  parameter int unsigned HI_FAST  = 32,
  parameter int unsigned LO_FAST  = 32,
  parameter int unsigned DLY_SLOW = 320,
  parameter int unsigned HI_SLOW  = 128,
  parameter int unsigned LO_SLOW  = 128
) (
  input logic       clk,
  input logic       rst_n,
  input logic       dir_sel_i,
  input logic       sclk_o,
  input logic       sym_valid_o,
  input logic       sym_ready_i,
  input logic [5:0] sym_data_o,
  input logic       sym_blk_o
);
  localparam int unsigned DMIN = (DLY_FAST < DLY_SLOW) ? DLY_FAST : DLY_SLOW;
  logic [15:0] hi_run, lo_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0;
      lo_run <= '0;
    end else begin
      hi_run <= !sclk_o ? 16'd0 : ((hi_run == 16'hFFFF) ? hi_run : hi_run + 16'd1);
      lo_run <= sclk_o  ? 16'd0 : ((lo_run == 16'hFFFF) ? lo_run : lo_run + 16'd1);
    end
  end

  assert_ext_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dir_sel_i) |-> !sclk_o);

  assert_high_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_o) |-> (32'(hi_run) == HI_FAST || 32'(hi_run) == HI_SLOW));

  assert_low_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> (32'(lo_run) == LO_FAST || 32'(lo_run) == LO_SLOW ||
                       32'(lo_run) >= DMIN));

  assert_hold_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid_o && !sym_ready_i) |=> sym_valid_o);

  assert_accept_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid_o && sym_ready_i && !sclk_o && !dir_sel_i) |=> !sym_valid_o);
endmodule

bind subcode_shift_rx subcode_shift_rx_chk #(
  .DLY_FAST(DLY_FAST), .HI_FAST(HI_FAST), .LO_FAST(LO_FAST),
  .DLY_SLOW(DLY_SLOW), .HI_SLOW(HI_SLOW), .LO_SLOW(LO_SLOW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dir_sel_i(dir_sel_i), .sclk_o(sclk_o),
  .sym_valid_o(sym_valid_o), .sym_ready_i(sym_ready_i),
  .sym_data_o(sym_data_o), .sym_blk_o(sym_blk_o)
);

// File: tb/subcode_shift_rx_tb_top.sv
`timescale 1ns/1ps
module subcode_shift_rx_tb_top;
  localparam int DF = 12, HF = 3, LF = 3, DS = 20, HS = 5, LS = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fsync = 0, bsync = 0, sdata = 0, dir = 0, spd = 0, ext = 0, rdy = 1;
  logic sclk;
  logic [5:0] sdat;
  logic sblk, svalid;

  int total = 0, bad = 0;
  logic [6:0] exp_q[$];
  int rises = 0, last_hi = 0, hi_cnt = 0, lead = 0, lead_cnt = 0;
  bit  lead_run = 0;

  always #10 clk = ~clk;

  subcode_shift_rx #(.DLY_FAST(DF), .HI_FAST(HF), .LO_FAST(LF),
                     .DLY_SLOW(DS), .HI_SLOW(HS), .LO_SLOW(LS)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_sync_i(fsync), .block_sync_i(bsync),
    .sdata_i(sdata), .dir_sel_i(dir), .speed_sel_i(spd), .sclk_ext_i(ext),
    .sclk_o(sclk), .sym_data_o(sdat), .sym_blk_o(sblk), .sym_valid_o(svalid),
    .sym_ready_i(rdy));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pulse measurements and scoreboard
  always @(negedge clk) begin
    if (sclk) begin
      hi_cnt++;
    end else if (hi_cnt != 0) begin
      last_hi = hi_cnt;
      hi_cnt = 0;
    end
    if (lead_run) begin
      if (sclk) lead_run = 0; else lead_cnt++;
    end
    if (svalid && rdy) begin
      if (exp_q.size() == 0) begin
        check(0, "R6 unexpected symbol", int'(sdat), -1);
      end else begin
        logic [6:0] e;
        e = exp_q.pop_front();
        check({sblk, sdat} == e, "R5/R7 symbol", int'({sblk, sdat}), int'(e));
      end
    end
  end

  always @(posedge sclk) rises++;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_fsync();
    fsync = 1; wait_clk(4); fsync = 0;
  endtask

  task automatic pulse_bsync();
    bsync = 1; wait_clk(4); bsync = 0; wait_clk(2);
  endtask

  // generator-mode frame; mid_at >= 0 injects a frame sync after that many pulses
  task automatic gen_frame(input logic [7:0] bits, input bit blk, input int mid_at);
    if (blk) pulse_bsync();
    exp_q.push_back({blk, bits[5:0]});
    rises = 0;
    sdata = bits[7];
    lead_cnt = 0; lead_run = 1;
    pulse_fsync();
    for (int i = 7; i >= 0; i--) begin
      sdata = bits[i];
      @(posedge sclk);
      if (7 - i + 1 == mid_at) fsync = 1;
      @(negedge sclk);
      wait_clk(1);
      fsync = 0;
    end
    wait_clk(20);
    lead = lead_cnt;
  endtask

  task automatic ext_bits(input logic [7:0] bits, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdata = bits[i]; wait_clk(4);
      ext = 1; wait_clk(4);
      ext = 0; wait_clk(4);
    end
  endtask

  initial begin : main
    int r0;
    wait_clk(3);
    check(sclk == 1'b0, "R1 sclk_o in reset", int'(sclk), 0);
    check(svalid == 1'b0, "R1 valid in reset", int'(svalid), 0);
    rst_n = 1; wait_clk(3);
    check(sclk == 1'b0 && svalid == 1'b0, "R1 idle after reset", int'({sclk, svalid}), 0);

    // fast timing set
    spd = 0;
    gen_frame(8'b10_101101, 0, -1);
    check(rises == 8, "R2 pulse count fast", rises, 8);
    check(last_hi == HF, "R3 high width fast", last_hi, HF);
    check(lead >= DF && lead <= DF + 5, "R2 lead-in fast", lead, DF);
    gen_frame(8'b01_010010, 1, -1);
    gen_frame(8'b11_111111, 0, -1);
    check(exp_q.size() == 0, "R5 fast frames delivered", exp_q.size(), 0);

    // slow timing set
    spd = 1;
    gen_frame(8'b00_110001, 1, -1);
    check(rises == 8, "R2 pulse count slow", rises, 8);
    check(last_hi == HS, "R3 high width slow", last_hi, HS);
    check(lead >= DS && lead <= DS + 5, "R3 lead-in slow", lead, DS);
    check(exp_q.size() == 0, "R7 slow frame delivered", exp_q.size(), 0);

    // frame sync in the middle of a burst
    spd = 0;
    gen_frame(8'b01_100110, 0, 2);
    check(rises == 8, "R8 pulse count with mid sync", rises, 8);
    wait_clk(40);
    check(exp_q.size() == 0 && !svalid, "R8 single symbol", exp_q.size(), 0);

    // back-pressure and overwrite
    rdy = 0;
    gen_frame(8'b00_000111, 0, -1);
    check(svalid == 1'b1, "R6 valid held", int'(svalid), 1);
    wait_clk(30);
    check(svalid && sdat == 6'b000111, "R6 data stable", int'(sdat), 7);
    gen_frame(8'b11_111000, 1, -1);
    check(svalid && sdat == 6'b111000 && sblk, "R6 overwrite", int'({sblk, sdat}), 'h78);
    void'(exp_q.pop_front());
    wait_clk(1); rdy = 1; wait_clk(3);
    check(exp_q.size() == 0 && !svalid, "R6 newest delivered", exp_q.size(), 0);

    // external clock mode
    dir = 1; wait_clk(4);
    r0 = rises;
    exp_q.push_back({1'b0, 6'b101010});
    pulse_fsync(); wait_clk(4);
    ext_bits(8'b11_101010, 8);
    wait_clk(10);
    check(exp_q.size() == 0, "R4 external frame", exp_q.size(), 0);
    check(rises == r0, "R4 sclk_o quiet", rises - r0, 0);

    // partial frame discarded by frame sync
    pulse_fsync(); wait_clk(4);
    ext_bits(8'b11_111111, 3);
    exp_q.push_back({1'b1, 6'b011001});
    pulse_bsync();
    pulse_fsync(); wait_clk(4);
    ext_bits(8'b00_011001, 8);
    wait_clk(10);
    check(exp_q.size() == 0 && !svalid, "R9 resync external", exp_q.size(), 0);
    check(rises == r0, "R4 sclk_o quiet after resync", rises - r0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule